// File: doc/BRIEF.md
# Radio Bit-Clocking Serializer Accelerator

This block sits between a host that works in whole bytes and the single data pin of an on-off-keyed radio. On transmit, the host chooses when to start, after its own channel-access delay. It hands over a first byte with a start command and then feeds further bytes into a one-byte holding register when the block asks for them. The block shifts every byte out most significant bit first. Each bit lasts exactly one bit period, counted in timer ticks.

On receive, the radio data pin is synchronised to the clock, and every transition is stamped with the free-running tick timer. Each clock cycle is one timer tick, so a 4 MHz clock gives quarter-microsecond resolution and an 80-tick bit period at 50 kb/s. The host searches for the start symbol itself. Once it has found one, it raises the receive enable. The block then samples the line half a bit period after the most recent edge, and once per bit period after that. Each new data edge restarts that phase, so slow drift between the two ends is absorbed. Every eight samples form a byte, which is handed to the host with a one-cycle strobe.

Top module: `bitclk_accel`

## Requirements
- R1: After reset, tx_o, tx_busy_o, tx_req_o, tx_underrun_o and rx_valid_o are all 0.
- R2: After a tx_start_i while idle, tx_o carries the bits of tx_data_i, most significant bit first. The first bit appears in the cycle after the start, and each bit is held for exactly BIT_TICKS clock cycles.
- R3: tx_req_o pulses for one cycle each time the shift register is loaded: in the cycle after an accepted start, and in the cycle after each reload from the next byte. It is 0 at the end of transmission.
- R4: A tx_wr_i pulse while busy and while the holding register is empty captures tx_data_i and tx_last_i. That byte follows the current one with no gap on the line.
- R5: After the final bit of a byte marked by tx_last_i, tx_o goes to 0, tx_busy_o goes to 0, and tx_underrun_o stays 0.
- R6: If a byte that is not marked last ends while no next byte is held, tx_underrun_o goes to 1, tx_o goes to 0 and tx_busy_o goes to 0. The flag stays set until the next accepted start.
- R7: A tx_start_i while tx_busy_o is 1 is ignored: the bits on tx_o are unchanged.
- R8: rx_stamp_o holds the timer value at the most recent synchronised rx_i transition and changes only on a transition. The difference between two stamps equals the spacing of the transitions in clock cycles.
- R9: While rx_en_i is 1, the line is sampled HALF_TICKS cycles after the last edge and every BIT_TICKS cycles after that. Samples are shifted in most significant bit first, and rx_valid_o pulses for one cycle with rx_byte_o after every eighth sample.
- R10: While rx_en_i is 0, no sample is taken and rx_valid_o stays 0. The bit count restarts from zero when rx_en_i is raised.
- R11: Every rx_i edge restarts the sampling phase, so packets whose real bit period is within 78 to 82 ticks are received correctly over several bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one timer tick per cycle |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_start_i | input | 1 | Start transmission with tx_data_i as first byte |
| tx_wr_i | input | 1 | Write next byte into the holding register |
| tx_data_i | input | 8 | Byte for start or write |
| tx_last_i | input | 1 | Marks the supplied byte as the final one |
| tx_o | output | 1 | Radio transmit data |
| tx_busy_o | output | 1 | Transmission in progress |
| tx_req_o | output | 1 | Next-byte request strobe |
| tx_underrun_o | output | 1 | Sticky underrun flag |
| rx_i | input | 1 | Radio receive data, asynchronous |
| rx_en_i | input | 1 | Start symbol found, bit clocking enabled |
| rx_stamp_o | output | 16 | Timer value at the latest receive edge |
| rx_byte_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | Received byte strobe |

## Verification
The bench drives receive packets at bit periods of 78 to 82 ticks, including long runs of identical bits. A design that did not restart its phase on each edge would drift off the bit centre and return wrong bytes. Transmit runs write the next byte during an earlier bit and inject a stray start mid-byte. A design that reloaded late, or obeyed the stray start, would show wrong bit values at the bit mid-points. Runs that end without a last marker must raise the underrun flag and leave the line low, while properly terminated runs must not. Receive traffic with the enable held low must produce no byte strobe, and the stamp differences are compared against random edge spacings.

// File: rtl/bitclk_pkg.sv
package bitclk_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/bitclk_edge_stamp.sv
module bitclk_edge_stamp #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAMP_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rx_i,
  output logic               level_o,
  output logic               edge_o,
  output logic [STAMP_W-1:0] stamp_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [STAMP_W-1:0]     now_q;
  logic [STAMP_W-1:0]     stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      now_q   <= '0;
      stamp_q <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
      prev_q <= sync_q[SYNC_STAGES-1];
      now_q  <= now_q + STAMP_W'(1);
      if (edge_o) stamp_q <= now_q;
    end
  end

  assign level_o = sync_q[SYNC_STAGES-1];
  assign edge_o  = sync_q[SYNC_STAGES-1] ^ prev_q;
  assign stamp_o = stamp_q;

  p_stamp_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(edge_o) |-> $stable(stamp_q));
endmodule

// File: rtl/bitclk_tx_ser.sv
module bitclk_tx_ser
  import bitclk_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 80
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  start_i,
  input  logic  wr_i,
  input  byte_t data_i,
  input  logic  last_i,
  output logic  tx_o,
  output logic  busy_o,
  output logic  req_o,
  output logic  underrun_o
);
  localparam int unsigned CNT_W = $clog2(BIT_TICKS);
  localparam int unsigned IDX_W = $clog2(BYTE_W);

  byte_t            shift_q, hold_q;
  logic             busy_q, cur_last_q, hold_full_q, hold_last_q;
  logic             req_q, underrun_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;

  logic  bit_end, byte_end, nxt_avail, nxt_last;
  byte_t nxt_data;

  assign bit_end   = (cnt_q == CNT_W'(BIT_TICKS - 1));
  assign byte_end  = bit_end && (idx_q == IDX_W'(BYTE_W - 1));
  assign nxt_avail = hold_full_q | wr_i;
  assign nxt_data  = hold_full_q ? hold_q : data_i;
  assign nxt_last  = hold_full_q ? hold_last_q : last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q     <= '0;
      hold_q      <= '0;
      busy_q      <= 1'b0;
      cur_last_q  <= 1'b0;
      hold_full_q <= 1'b0;
      hold_last_q <= 1'b0;
      req_q       <= 1'b0;
      underrun_q  <= 1'b0;
      cnt_q       <= '0;
      idx_q       <= '0;
    end else begin
      req_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          shift_q     <= data_i;
          cur_last_q  <= last_i;
          busy_q      <= 1'b1;
          cnt_q       <= '0;
          idx_q       <= '0;
          req_q       <= 1'b1;
          underrun_q  <= 1'b0;
          hold_full_q <= 1'b0;
        end
      end else begin
        if (wr_i && !hold_full_q) begin
          hold_q      <= data_i;
          hold_last_q <= last_i;
          hold_full_q <= 1'b1;
        end
        if (!bit_end) begin
          cnt_q <= cnt_q + CNT_W'(1);
        end else begin
          cnt_q <= '0;
          if (!byte_end) begin
            shift_q <= {shift_q[BYTE_W-2:0], 1'b0};
            idx_q   <= idx_q + IDX_W'(1);
          end else if (cur_last_q) begin
            busy_q <= 1'b0;
          end else if (nxt_avail) begin
            shift_q     <= nxt_data;
            cur_last_q  <= nxt_last;
            hold_full_q <= 1'b0;
            idx_q       <= '0;
            req_q       <= 1'b1;
          end else begin
            busy_q     <= 1'b0;
            underrun_q <= 1'b1;
          end
        end
      end
    end
  end

  assign tx_o       = busy_q & shift_q[BYTE_W-1];
  assign busy_o     = busy_q;
  assign req_o      = req_q;
  assign underrun_o = underrun_q;

  p_req_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> busy_q);
  p_underrun_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_q |-> !busy_q);
  p_bit_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cnt_q != '0) |-> $stable(tx_o));
endmodule

// File: rtl/bitclk_rx_deser.sv
module bitclk_rx_deser
  import bitclk_pkg::*;
#(
  parameter int unsigned BIT_TICKS = 80
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  level_i,
  input  logic  edge_i,
  output byte_t byte_o,
  output logic  valid_o
);
  localparam int unsigned CNT_W      = $clog2(BIT_TICKS);
  localparam int unsigned IDX_W      = $clog2(BYTE_W);
  localparam int unsigned HALF_TICKS = BIT_TICKS / 2;

  logic [CNT_W-1:0] ph_q;
  logic [IDX_W-1:0] idx_q;
  byte_t            shift_q, byte_q;
  logic             valid_q;
  logic             sample;
  byte_t            shifted;

  assign sample  = en_i && !edge_i && (ph_q == CNT_W'(HALF_TICKS));
  assign shifted = {shift_q[BYTE_W-2:0], level_i};

  // phase restarts on every edge, wraps each bit period otherwise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             ph_q <= '0;
    else if (edge_i)                         ph_q <= '0;
    else if (ph_q == CNT_W'(BIT_TICKS - 1))  ph_q <= '0;
    else                                     ph_q <= ph_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      shift_q <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (!en_i) begin
        idx_q <= '0;
      end else if (sample) begin
        shift_q <= shifted;
        if (idx_q == IDX_W'(BYTE_W - 1)) begin
          idx_q   <= '0;
          byte_q  <= shifted;
          valid_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  p_valid_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |-> $past(en_i));
  p_phase_restart_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(edge_i) |-> (ph_q == '0));
  p_valid_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/bitclk_accel.sv
module bitclk_accel
  import bitclk_pkg::*;
#(
  parameter int unsigned BIT_TICKS   = 80,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STAMP_W     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_start_i,
  input  logic               tx_wr_i,
  input  logic [7:0]         tx_data_i,
  input  logic               tx_last_i,
  output logic               tx_o,
  output logic               tx_busy_o,
  output logic               tx_req_o,
  output logic               tx_underrun_o,
  input  logic               rx_i,
  input  logic               rx_en_i,
  output logic [STAMP_W-1:0] rx_stamp_o,
  output logic [7:0]         rx_byte_o,
  output logic               rx_valid_o
);
  logic rx_level, rx_edge;

  bitclk_tx_ser #(.BIT_TICKS(BIT_TICKS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (tx_start_i),
    .wr_i       (tx_wr_i),
    .data_i     (tx_data_i),
    .last_i     (tx_last_i),
    .tx_o       (tx_o),
    .busy_o     (tx_busy_o),
    .req_o      (tx_req_o),
    .underrun_o (tx_underrun_o)
  );

  bitclk_edge_stamp #(.SYNC_STAGES(SYNC_STAGES), .STAMP_W(STAMP_W)) u_stamp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rx_i    (rx_i),
    .level_o (rx_level),
    .edge_o  (rx_edge),
    .stamp_o (rx_stamp_o)
  );

  bitclk_rx_deser #(.BIT_TICKS(BIT_TICKS)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (rx_en_i),
    .level_i (rx_level),
    .edge_i  (rx_edge),
    .byte_o  (rx_byte_o),
    .valid_o (rx_valid_o)
  );
endmodule

// File: tb/bitclk_accel_tb_top.sv
module bitclk_accel_tb_top;
  localparam int BIT = 80;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_start = 1'b0, tx_wr = 1'b0, tx_last = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_line, tx_busy, tx_req, tx_uf;
  logic        rx = 1'b0, rx_en = 1'b0;
  logic [15:0] stamp;
  logic [7:0]  rx_byte;
  logic        rx_valid;

  int checks = 0, errors = 0;
  logic [7:0] exp_rx [0:15];
  int rx_exp_n = 0, rx_got = 0;

  always #10 clk = ~clk;

  bitclk_accel dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .tx_start_i(tx_start), .tx_wr_i(tx_wr), .tx_data_i(tx_data), .tx_last_i(tx_last),
    .tx_o(tx_line), .tx_busy_o(tx_busy), .tx_req_o(tx_req), .tx_underrun_o(tx_uf),
    .rx_i(rx), .rx_en_i(rx_en), .rx_stamp_o(stamp),
    .rx_byte_o(rx_byte), .rx_valid_o(rx_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit bit_of(input logic [7:0] b, input int i);
    return b[7-i];
  endfunction

  // receive monitor: R9 byte order and content
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (rx_got < rx_exp_n) chk(rx_byte == exp_rx[rx_got], "R9 rx byte", rx_byte, exp_rx[rx_got]);
      else chk(1'b0, "R10 unexpected rx strobe", rx_byte, -1);
      rx_got++;
    end
  end

  // uflow=1: no last marker, expect underrun after final byte
  task automatic tx_run(input int n, input bit uflow, input bit stray);
    logic [7:0] d [0:7];
    for (int i = 0; i < n; i++) d[i] = 8'($urandom);
    @(negedge clk);
    tx_start = 1'b1; tx_data = d[0]; tx_last = (n == 1) && !uflow;
    for (int c = 1; c <= 640*n + 1; c++) begin
      @(negedge clk);
      tx_start = 1'b0; tx_wr = 1'b0;
      if (c % 640 == 1) begin
        if (c <= 640*(n-1) + 1) chk(tx_req == 1'b1, "R3 req on load", tx_req, 1);
        else chk(tx_req == 1'b0, "R3 no req at end", tx_req, 0);
      end
      if ((c % 640) >= 40 && ((c % 640) - 40) % 80 == 0 && c < 640*n) begin
        chk(tx_line == bit_of(d[c/640], (c % 640)/80),
            (c < 640) ? "R2 tx bit" : "R4 tx next byte bit",
            tx_line, bit_of(d[c/640], (c % 640)/80));
      end
      if (c % 640 == 200 && c/640 + 1 < n) begin
        tx_wr = 1'b1; tx_data = d[c/640 + 1];
        tx_last = (c/640 + 1 == n - 1) && !uflow;
      end
      if (stray && c == 300) begin
        tx_start = 1'b1; tx_data = ~d[0]; tx_last = 1'b1; // R7
      end
    end
    chk(tx_busy == 1'b0, uflow ? "R6 busy low" : "R5 busy low", tx_busy, 0);
    chk(tx_line == 1'b0, uflow ? "R6 line low" : "R5 line low", tx_line, 0);
    chk(tx_uf == uflow, uflow ? "R6 underrun set" : "R5 no underrun", tx_uf, uflow);
  endtask

  task automatic rx_packet(input int n, input int per, input bit en, input bit fixed);
    logic [7:0] ss = 8'b1110_0101;
    logic [7:0] d [0:3];
    for (int i = 0; i < n; i++) begin
      d[i] = fixed ? ((i % 2 == 0) ? 8'hFF : 8'h00) : 8'($urandom);
      if (en) exp_rx[rx_exp_n + i] = d[i];
    end
    for (int b = 0; b < 8; b++) begin
      @(negedge clk); rx = ss[7-b];
      repeat (per - 1) @(negedge clk);
    end
    for (int b = 0; b < 8*n; b++) begin
      @(negedge clk); rx = d[b/8][7 - b%8];
      if (b == 0) begin
        repeat (10) @(negedge clk);
        rx_en = en;
        if (en) rx_exp_n = rx_exp_n + n;
        repeat (per - 11) @(negedge clk);
      end else repeat (per - 1) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk); rx = 1'b0;
    repeat (200) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int prev_stamp, gap, base;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(tx_line == 0 && tx_busy == 0 && tx_req == 0, "R1 tx reset", {tx_line, tx_busy, tx_req}, 0);
    chk(tx_uf == 0 && rx_valid == 0, "R1 flags reset", {tx_uf, rx_valid}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_busy == 0 && rx_valid == 0, "R1 idle after reset", {tx_busy, rx_valid}, 0);

    // R8 stamp spacing
    prev_stamp = -1;
    for (int e = 0; e < 8; e++) begin
      gap = 6 + int'($urandom_range(0, 200));
      @(negedge clk); rx = ~rx;
      repeat (5) @(negedge clk);
      if (prev_stamp >= 0) chk(int'(stamp) - prev_stamp == base, "R8 stamp delta", int'(stamp) - prev_stamp, base);
      prev_stamp = int'(stamp);
      base = gap + 6;
      repeat (gap) @(negedge clk);
      chk(int'(stamp) == prev_stamp, "R8 stamp held", stamp, prev_stamp);
    end
    if (rx) begin @(negedge clk); rx = 1'b0; end
    repeat (100) @(negedge clk);

    // transmit
    tx_run(1, 1'b0, 1'b0);
    tx_run(3, 1'b0, 1'b1);
    tx_run(2, 1'b1, 1'b0);
    tx_run(4, 1'b0, 1'b0);
    tx_run(1, 1'b1, 1'b0);
    tx_run(2, 1'b0, 1'b1);
    chk(tx_uf == 0, "R6 flag cleared by start", tx_uf, 0);

    // receive
    rx_packet(3, 80, 1'b1, 1'b0);
    chk(rx_got == rx_exp_n, "R9 byte count nominal", rx_got, rx_exp_n);
    rx_packet(2, 80, 1'b0, 1'b0);
    chk(rx_got == rx_exp_n, "R10 disabled no strobe", rx_got, rx_exp_n);
    rx_packet(3, 82, 1'b1, 1'b1);
    chk(rx_got == rx_exp_n, "R11 slow runs", rx_got, rx_exp_n);
    rx_packet(3, 78, 1'b1, 1'b1);
    chk(rx_got == rx_exp_n, "R11 fast runs", rx_got, rx_exp_n);
    for (int k = 0; k < 3; k++) begin
      rx_packet(2, 78 + int'($urandom_range(0, 4)), 1'b1, 1'b0);
      chk(rx_got == rx_exp_n, "R11 random period", rx_got, rx_exp_n);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule